// File: doc/BRIEF.md
# Error Interrupt Poster with Priority Vector

This block raises one high-priority error interrupt when any bit of a set of error status inputs is set. The set covers the internal error flags together with the external link's power-good transition flag and its link error flag, and all of them are treated alike. Software first writes a unique error vector into a vector register and then sets an enable bit. From then on, the first error that appears while the block is armed posts the interrupt. The block stays disarmed until every error input has returned to zero.

Device interrupt vectors arrive through a push port and wait in a four-entry queue. An interrupt-acknowledge read returns the pending error vector first, even if the device vectors were queued before the error was posted. When no error is pending, the read returns the oldest queued device vector and removes it. When nothing is pending, it returns zero. The interrupt request output is high whenever an error is pending or the queue holds a device vector.

Top module: `err_irq_poster`

## Requirements
- R1: After reset, `irq` is low and an acknowledge read returns zero.
- R2: While the enable bit is clear, error inputs post nothing: `irq` stays low and an acknowledge read returns zero.
- R3: While the enable bit is set and the block is armed, any single error input at 1 (each of the `NUM_ERR` bit positions) posts the error interrupt. `irq` is high from the clock edge that samples the error.
- R4: After a posting, no further posting occurs while any error input is still 1, whatever other bits change. Once all error inputs have read 0 on a clock edge, the next error posts again.
- R5: While an error is pending, an acknowledge read returns the vector register contents ahead of queued device vectors, regardless of arrival order.
- R6: An acknowledge read that returns the error vector clears the pending error. The error vector is not returned again until a new posting.
- R7: Device vectors are returned oldest first from a queue of 4 entries. A push while 4 entries are held is dropped.
- R8: An acknowledge read with no pending error and an empty queue returns zero and changes nothing.
- R9: `irq` is high exactly while an error is pending or the queue is non-empty. It falls only after an acknowledge read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_bits | input | NUM_ERR | Level error status flags, including the link power-good transition and link error flags |
| cfg_vec_we | input | 1 | Write strobe for the error vector register |
| cfg_vec_wdata | input | VEC_W | Error vector write data |
| cfg_en_we | input | 1 | Write strobe for the enable bit |
| cfg_en_wdata | input | 1 | Enable bit write data |
| dev_push | input | 1 | Queue a device interrupt vector |
| dev_vec | input | VEC_W | Device vector to queue |
| ack_rd | input | 1 | Interrupt-acknowledge read strobe |
| ack_vec | output | VEC_W | Vector returned by the acknowledge read in the same cycle |
| irq | output | 1 | Interrupt request |

## Verification
The block samples an error input, a push or a configuration write on a rising edge, and the resulting `irq` level is visible right after that same edge. The bench drives every stimulus at the falling edge and samples `irq` at the next falling edge. `ack_vec` is combinational while `ack_rd` is high, so the bench reads it shortly after raising the strobe and before the edge that commits the pop or clear. The sweeps post from each error bit position in turn and fill the queue with zero to five vectors, with and without a later error. For each sweep the bench computes the expected read order from a small queue model of its own.

// File: rtl/err_irq_pkg.sv
// err_irq_pkg: shared types for the error interrupt poster.
// Assumes: used by all modules of err_irq_poster.
package err_irq_pkg;
    // Source selected for an acknowledge read.
    typedef enum logic [1:0] {
        ACK_NONE = 2'd0,
        ACK_ERR  = 2'd1,
        ACK_DEV  = 2'd2
    } ack_src_e;
endpackage

// File: rtl/eip_err_arm.sv
// eip_err_arm: posts an error interrupt once per error episode.
// Posts when enabled and armed and any error input is set. Re-arms only on
// a cycle where every error input reads zero. Assumes error inputs are levels.
module eip_err_arm #(
    parameter int NUM_ERR = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [NUM_ERR-1:0] err_bits,
    input  logic               take,
    output logic               pend,
    output logic               armed
);
    logic any_err;
    logic post;

    // Reduce the error inputs and decide whether to post this cycle.
    always_comb begin
        any_err = |err_bits;
        post    = en && armed && any_err;
    end

    // Track the arm state and the pending flag; a new posting beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b1;
            pend  <= 1'b0;
        end else begin
            if (!any_err)  armed <= 1'b1;
            else if (post) armed <= 1'b0;
            if (post)      pend  <= 1'b1;
            else if (take) pend  <= 1'b0;
        end
    end
endmodule

// File: rtl/eip_vec_fifo.sv
// eip_vec_fifo: small first-in first-out queue of device vectors.
// Assumes: a push while full is dropped; a pop while empty is ignored.
module eip_vec_fifo #(
    parameter int VEC_W = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [VEC_W-1:0] din,
    input  logic             pop,
    output logic [VEC_W-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [VEC_W-1:0] slot [DEPTH];
    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;
    logic [CW-1:0]    count;
    logic             do_push;
    logic             do_pop;

    // Qualify the push and pop strobes and derive the status flags.
    always_comb begin
        empty   = (count == '0);
        full    = (count == CW'(DEPTH));
        do_push = push && !full;
        do_pop  = pop && !empty;
        dout    = slot[rd_ptr];
    end

    // One storage register per entry, written when the write pointer selects it.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)                              slot[g] <= '0;
            else if (do_push && wr_ptr == PW'(g))    slot[g] <= din;
        end
    end

    // Advance the pointers with wrap-around and keep the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/eip_ack_sel.sv
// eip_ack_sel: chooses what an acknowledge read returns.
// Priority: pending error vector, then the oldest device vector, then zero.
// Assumes: all inputs are registered state, so the output is glitch-free per cycle.
module eip_ack_sel
    import err_irq_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             ack_rd,
    input  logic             pend,
    input  logic [VEC_W-1:0] err_vec,
    input  logic             fifo_empty,
    input  logic [VEC_W-1:0] fifo_head,
    output logic [VEC_W-1:0] ack_vec,
    output logic             err_take,
    output logic             dev_pop
);
    ack_src_e src;

    // Pick the source by fixed priority and form the side-effect strobes.
    always_comb begin
        if (pend)             src = ACK_ERR;
        else if (!fifo_empty) src = ACK_DEV;
        else                  src = ACK_NONE;
        case (src)
            ACK_ERR: ack_vec = err_vec;
            ACK_DEV: ack_vec = fifo_head;
            default: ack_vec = '0;
        endcase
        err_take = ack_rd && (src == ACK_ERR);
        dev_pop  = ack_rd && (src == ACK_DEV);
    end
endmodule

// File: rtl/err_irq_poster.sv
// err_irq_poster: error interrupt poster with a priority error vector.
// Holds the error vector and enable bit, posts one interrupt per error episode,
// queues device vectors and serves acknowledge reads with the error first.
// Assumes: error inputs are level flags held until software clears them.
module err_irq_poster #(
    parameter int NUM_ERR   = 6,
    parameter int VEC_W     = 8,
    parameter int DEV_DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ERR-1:0] err_bits,
    input  logic               cfg_vec_we,
    input  logic [VEC_W-1:0]   cfg_vec_wdata,
    input  logic               cfg_en_we,
    input  logic               cfg_en_wdata,
    input  logic               dev_push,
    input  logic [VEC_W-1:0]   dev_vec,
    input  logic               ack_rd,
    output logic [VEC_W-1:0]   ack_vec,
    output logic               irq
);
    logic [VEC_W-1:0] err_vec_q;
    logic             en_q;
    logic             err_pend;
    logic             armed;
    logic             err_take;
    logic             dev_pop;
    logic             fifo_empty;
    logic             fifo_full;
    logic [VEC_W-1:0] fifo_head;

    // Configuration registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_vec_q <= '0;
            en_q      <= 1'b0;
        end else begin
            if (cfg_vec_we) err_vec_q <= cfg_vec_wdata;
            if (cfg_en_we)  en_q      <= cfg_en_wdata;
        end
    end

    eip_err_arm #(.NUM_ERR(NUM_ERR)) u_arm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_q),
        .err_bits (err_bits),
        .take     (err_take),
        .pend     (err_pend),
        .armed    (armed)
    );

    eip_vec_fifo #(.VEC_W(VEC_W), .DEPTH(DEV_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (dev_push),
        .din   (dev_vec),
        .pop   (dev_pop),
        .dout  (fifo_head),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    eip_ack_sel #(.VEC_W(VEC_W)) u_sel (
        .ack_rd     (ack_rd),
        .pend       (err_pend),
        .err_vec    (err_vec_q),
        .fifo_empty (fifo_empty),
        .fifo_head  (fifo_head),
        .ack_vec    (ack_vec),
        .err_take   (err_take),
        .dev_pop    (dev_pop)
    );

    // Request while any interrupt source has something pending.
    always_comb irq = err_pend || !fifo_empty;
endmodule

// File: rtl/eip_checker.sv
// eip_checker: temporal properties of err_irq_poster, attached by bind.
// Assumes: sees the top module's ports and its arm, enable and queue state.
module eip_checker #(
    parameter int NUM_ERR = 6,
    parameter int VEC_W   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en_q,
    input logic               armed,
    input logic               pend,
    input logic [NUM_ERR-1:0] err_bits,
    input logic               ack_rd,
    input logic [VEC_W-1:0]   ack_vec,
    input logic [VEC_W-1:0]   err_vec_q,
    input logic               fifo_empty,
    input logic               irq
);
    p_no_post_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !pend) |=> !pend);

    p_post_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && armed && (|err_bits)) |=> pend);

    p_hold_disarmed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && (|err_bits)) |=> !armed);

    p_rearm_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_bits == '0) |=> armed);

    p_err_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && pend) |-> (ack_vec == err_vec_q));

    p_err_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && pend && !(en_q && armed && (|err_bits))) |=> !pend);

    p_zero_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !pend && fifo_empty) |-> (ack_vec == '0));

    p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(ack_rd));
endmodule

bind err_irq_poster eip_checker #(.NUM_ERR(NUM_ERR), .VEC_W(VEC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_q       (en_q),
    .armed      (armed),
    .pend       (err_pend),
    .err_bits   (err_bits),
    .ack_rd     (ack_rd),
    .ack_vec    (ack_vec),
    .err_vec_q  (err_vec_q),
    .fifo_empty (fifo_empty),
    .irq        (irq)
);

// File: tb/err_irq_poster_bench.sv
// err_irq_poster_bench: sweeps error bit positions and queue fill levels,
// comparing against expectations computed from the requirements.
module err_irq_poster_bench;
    localparam int NE = 6;
    localparam int VW = 8;
    localparam int DD = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NE-1:0] err_bits = '0;
    logic          cfg_vec_we = 1'b0;
    logic [VW-1:0] cfg_vec_wdata = '0;
    logic          cfg_en_we = 1'b0;
    logic          cfg_en_wdata = 1'b0;
    logic          dev_push = 1'b0;
    logic [VW-1:0] dev_vec = '0;
    logic          ack_rd = 1'b0;
    logic [VW-1:0] ack_vec;
    logic          irq;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    err_irq_poster #(.NUM_ERR(NE), .VEC_W(VW), .DEV_DEPTH(DD)) u_err_irq_poster (
        .clk(clk), .rst_n(rst_n), .err_bits(err_bits),
        .cfg_vec_we(cfg_vec_we), .cfg_vec_wdata(cfg_vec_wdata),
        .cfg_en_we(cfg_en_we), .cfg_en_wdata(cfg_en_wdata),
        .dev_push(dev_push), .dev_vec(dev_vec),
        .ack_rd(ack_rd), .ack_vec(ack_vec), .irq(irq)
    );

    // 125 MHz clock.
    always #4 clk = ~clk;

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog actual=%0d cycles expected=finish", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Acknowledge read: value sampled before the committing edge.
    task automatic ack(output logic [VW-1:0] v);
        ack_rd = 1'b1;
        #1 v = ack_vec;
        @(negedge clk);
        ack_rd = 1'b0;
    endtask

    task automatic push(input logic [VW-1:0] v);
        dev_push = 1'b1;
        dev_vec = v;
        @(negedge clk);
        dev_push = 1'b0;
    endtask

    task automatic write_vec(input logic [VW-1:0] v);
        cfg_vec_we = 1'b1;
        cfg_vec_wdata = v;
        @(negedge clk);
        cfg_vec_we = 1'b0;
    endtask

    task automatic write_en(input logic e);
        cfg_en_we = 1'b1;
        cfg_en_wdata = e;
        @(negedge clk);
        cfg_en_we = 1'b0;
    endtask

    initial begin
        logic [VW-1:0] v;
        logic [VW-1:0] model [DD];
        int            mcount;
        logic          with_err;
        logic [VW-1:0] evec;

        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1: reset state.
        check("R1 irq", int'(irq), 0);
        ack(v);
        check("R1 ack", int'(v), 0);

        // R2: vector loaded but enable clear, error present.
        write_vec(8'hA5);
        err_bits = 6'b000001;
        step(); step();
        check("R2 irq", int'(irq), 0);
        ack(v);
        check("R2 ack", int'(v), 0);
        err_bits = '0;
        step();
        write_en(1'b1);
        step();
        check("R2 irq after enable", int'(irq), 0);

        // R3 R4 R6: sweep every error bit position.
        for (int i = 0; i < NE; i++) begin
            evec = VW'(8'h40 + i);
            write_vec(evec);
            err_bits = NE'(1) << i;
            step();
            check("R3 irq", int'(irq), 1);
            ack(v);
            check("R3 R5 ack vec", int'(v), int'(evec));
            check("R6 irq after ack", int'(irq), 0);
            ack(v);
            check("R6 second ack", int'(v), 0);
            err_bits = (NE'(1) << i) | (NE'(1) << ((i + 1) % NE));
            step(); step();
            check("R4 no repost", int'(irq), 0);
            err_bits = NE'(1) << ((i + 1) % NE);
            step();
            check("R4 no repost partial", int'(irq), 0);
            err_bits = '0;
            step();
        end
        // R4: re-armed after all clear.
        err_bits = 6'b100000;
        step();
        check("R4 rearm repost", int'(irq), 1);
        ack(v);
        check("R4 rearm vec", int'(v), int'(VW'(8'h40 + NE - 1)));
        err_bits = '0;
        step();

        // R5 R7 R8 R9: queue fill sweep with and without a later error.
        write_vec(8'hEE);
        for (int n = 0; n <= DD + 1; n++) begin
            for (int w = 0; w < 2; w++) begin
                with_err = (w == 1);
                mcount = 0;
                for (int k = 0; k < n; k++) begin
                    v = VW'(8'h10 * (n + 1) + 2 * k + w + 1);
                    push(v);
                    if (mcount < DD) begin
                        model[mcount] = v;
                        mcount = mcount + 1;
                    end
                end
                if (with_err) begin
                    err_bits = NE'(1) << (n % NE);
                    step();
                end
                check("R9 irq level", int'(irq), int'(with_err || mcount > 0));
                if (with_err) begin
                    ack(v);
                    check("R5 err first", int'(v), 8'hEE);
                    check("R9 irq after err ack", int'(irq), int'(mcount > 0));
                end
                for (int k = 0; k < mcount; k++) begin
                    ack(v);
                    check("R7 order", int'(v), int'(model[k]));
                    check("R9 irq drain", int'(irq), int'(k < mcount - 1));
                end
                ack(v);
                check("R8 empty zero", int'(v), 0);
                check("R8 irq idle", int'(irq), 0);
                err_bits = '0;
                step();
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule